// File: doc/BRIEF.md
# Serial Link Response Poll and Retry Sequencer

This block sits above a serial link transceiver and runs one link transaction from request to final status. It starts the command frame through a handshake to the frame encoder, starts the response receiver, and classifies what comes back. A slave that reports busy is polled again with a data-poll frame. A response whose check code is corrupt is fetched again with an error-poll frame. A slave that reports a corrupt command gets the whole command again. A slave that stays busy too long is aborted with a terminate frame. Each retry, and the end of each response handling, is preceded by a fixed run of idle link clocks that the slave needs before it will listen again.

The same sequencer also produces the link reset pattern: a timed series of idle clocks at two data levels, which also tells the address tracker that its stored address is no longer valid. After reset it produces a long flush of idle clocks before it accepts the first request. While the link is handed to an external agent, every request is refused with a busy code and nothing is driven.

Each request finishes with a single-cycle `done` carrying an error code, the read data of an acknowledged response, and a flag that reports whether an abort attempt lost contact with the slave. Frame contents and bit timing belong to the neighbouring blocks. This block decides only which frame goes next and how many idle clocks come before it.

Top module: `lnk_poll_seq`

## Requirements
- R1: After reset the block drives exactly INIT_CLKS idle ticks (`idle_tick` high, `idle_level` 0) with `req_ready` low, then raises `req_ready`. No idle tick occurs while `req_ready` is high.
- R2: A transfer request sends one frame with `tx_kind` 0 (full command), then starts one response. An acknowledge (tag 0, check code good, no timeout) ends with `err` 0 and `rd_data` equal to `rx_data` of that response.
- R3: A busy response (tag 1) is followed by PAD_CLKS idle ticks and then a data-poll frame (`tx_kind` 1). Up to MAX_BUSY data-polls are sent within one command attempt.
- R4: A busy response that arrives after MAX_BUSY data-polls is followed by PAD_CLKS idle ticks and a terminate frame (`tx_kind` 3). The request then ends with `err` 2 (I/O error).
- R5: A response with a bad check code (`rx_crc_ok` 0, `rx_all_ones` 0) is followed by PAD_CLKS idle ticks and an error-poll frame (`tx_kind` 2), up to EPOLL_MAX times per attempt. The next such response ends the request with `err` 2.
- R6: A tag 3 response (slave saw a corrupt command) is followed by PRIME_CLKS idle ticks and a new full command, with fresh busy and error-poll budgets. After CMD_TRIES attempts in total the request ends with `err` 2.
- R7: A tag 2 response ends the request at once with `err` 2. A response timeout ends it with `err` 1.
- R8: Every handled response that ends a request or forces a resend is followed by exactly PRIME_CLKS idle ticks at level 0 before `done`.
- R9: A bad check code whose bits were all ones ends the request with `err` 3 (no device).
- R10: When the terminate frame's response is anything other than an acknowledge (including a timeout), `link_lost` is 1 with `done`. Otherwise it is 0.
- R11: While `ext_mode` is 1, a request (transfer or link reset) ends one cycle after acceptance with `err` 4, with no frame and no idle tick.
- R12: A link reset request drives BRK_LO_CLKS ticks at level 0, then BRK_HI_CLKS ticks at level 1, then ECHO_CLKS ticks at level 0, then BRK_SET_CLKS ticks at level 0. It ends with `err` 0 and `addr_inval` 1 for the `done` cycle. A transfer never raises `addr_inval`.
- R13: `done` is high for exactly one cycle per accepted request, and `err` uses only the codes 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | Link handed to an external agent; requests are refused |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_break | input | 1 | With `req_valid`: 1 = link reset, 0 = transfer |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| tx_start | output | 1 | One-cycle start of a frame to the encoder |
| tx_kind | output | 2 | Frame to send: 0 full command, 1 data-poll, 2 error-poll, 3 terminate |
| tx_done | input | 1 | Frame fully sent, including echo delay |
| rx_start | output | 1 | One-cycle start of response reception |
| rx_done | input | 1 | Response complete; the rx_* fields are valid |
| rx_tag | input | 2 | Response tag: 0 ack, 1 busy, 2 error, 3 command corrupt |
| rx_crc_ok | input | 1 | Response check code good |
| rx_timeout | input | 1 | No start bit seen within the receiver's limit |
| rx_all_ones | input | 1 | Every received bit was one |
| rx_data | input | DW | Response payload |
| idle_tick | output | 1 | One idle link clock this cycle |
| idle_level | output | 1 | Logical data level during the idle tick |
| done | output | 1 | Request finished (one cycle) |
| err | output | 3 | 0 ok, 1 timeout, 2 I/O error, 3 no device, 4 busy |
| rd_data | output | DW | Payload of the last acknowledge |
| link_lost | output | 1 | Abort attempt failed to get an acknowledge |
| addr_inval | output | 1 | Stored last address must be dropped |

## Verification
A scripted slave feeds response sequences to a reduced configuration, and the retry depths are swept from one step up to the limit and one step past it. Only a count of exactly the limit tells a correct bound from an off-by-one. Busy chains, bad-check chains and command-corrupt chains are each run on their own and in mixes. A mix of busy polls, a command resend and more busy polls shows whether the budgets are refreshed per attempt. Frame kinds and idle ticks are counted per request, and the ticks are split by level. These counts tell apart the pad after a poll, the priming run after a response, and the phases of the link reset, whose level-1 run must start after exactly the low-phase count.

// File: rtl/lnk_poll_pkg.sv
package lnk_poll_pkg;

    typedef enum logic [1:0] {
        TXK_FULL  = 2'd0,
        TXK_DPOLL = 2'd1,
        TXK_EPOLL = 2'd2,
        TXK_TERM  = 2'd3
    } txk_e;

    typedef enum logic [2:0] {
        ERR_OK    = 3'd0,
        ERR_TMO   = 3'd1,
        ERR_IO    = 3'd2,
        ERR_NODEV = 3'd3,
        ERR_BUSY  = 3'd4
    } err_e;

    localparam logic [1:0] TAG_ACK    = 2'd0;
    localparam logic [1:0] TAG_BUSY   = 2'd1;
    localparam logic [1:0] TAG_ERR    = 2'd2;
    localparam logic [1:0] TAG_CMDCRC = 2'd3;

    typedef enum logic [2:0] {
        V_ACK,
        V_BUSY,
        V_ERR,
        V_CMDCRC,
        V_BADCRC,
        V_NODEV,
        V_TMO
    } vrd_e;

    typedef enum logic [3:0] {
        S_PADL,
        S_PADW,
        S_IDLE,
        S_TX,
        S_TXW,
        S_RX,
        S_RXW,
        S_BRK,
        S_RESEND,
        S_DONE
    } st_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lnk_pacer.sv
// Emits a run of idle link ticks at a fixed data level.
module lnk_pacer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] len,
    input  logic          lvl,
    output logic          tick,
    output logic          level,
    output logic          fin
);
    logic [CW-1:0] left;
    logic          act;
    logic          lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act   <= 1'b0;
            left  <= '0;
            lvl_q <= 1'b0;
        end else if (start) begin
            act   <= (len != '0);
            left  <= len;
            lvl_q <= lvl;
        end else if (act) begin
            left <= left - 1'b1;
            if (left == CW'(1)) act <= 1'b0;
        end
    end

    assign tick  = act;
    assign level = act & lvl_q;
    assign fin   = act && (left == CW'(1));
endmodule

// File: rtl/lnk_bcnt.sv
// Bounded retry counter: reports when LIM increments have been taken.
module lnk_bcnt #(
    parameter int unsigned LIM = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_lim
);
    localparam int unsigned W = $clog2(LIM + 2);
    logic [W-1:0] val;

    always_ff @(posedge clk) begin
        if (rst || clr)  val <= '0;
        else if (inc)    val <= val + 1'b1;
    end

    assign at_lim = (val == W'(LIM));
endmodule

// File: rtl/lnk_verdict.sv
// Classifies one received response; timeout outranks check code, which outranks tag.
module lnk_verdict
    import lnk_poll_pkg::*;
(
    input  logic [1:0] tag,
    input  logic       crc_ok,
    input  logic       timeout,
    input  logic       all_ones,
    output vrd_e       verdict
);
    always_comb begin
        if (timeout)        verdict = V_TMO;
        else if (!crc_ok)   verdict = all_ones ? V_NODEV : V_BADCRC;
        else begin
            unique case (tag)
                TAG_ACK:    verdict = V_ACK;
                TAG_BUSY:   verdict = V_BUSY;
                TAG_ERR:    verdict = V_ERR;
                default:    verdict = V_CMDCRC;
            endcase
        end
    end
endmodule

// File: rtl/lnk_poll_seq.sv
module lnk_poll_seq
    import lnk_poll_pkg::*;
#(
    parameter int unsigned DW           = 32,
    parameter int unsigned INIT_CLKS    = 5000,
    parameter int unsigned PAD_CLKS     = 50,
    parameter int unsigned PRIME_CLKS   = 20,
    parameter int unsigned BRK_LO_CLKS  = 50,
    parameter int unsigned BRK_HI_CLKS  = 256,
    parameter int unsigned ECHO_CLKS    = 16,
    parameter int unsigned BRK_SET_CLKS = 16000,
    parameter int unsigned MAX_BUSY     = 200,
    parameter int unsigned EPOLL_MAX    = 11,
    parameter int unsigned CMD_TRIES    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ext_mode,
    input  logic          req_valid,
    input  logic          req_break,
    output logic          req_ready,
    output logic          tx_start,
    output logic [1:0]    tx_kind,
    input  logic          tx_done,
    output logic          rx_start,
    input  logic          rx_done,
    input  logic [1:0]    rx_tag,
    input  logic          rx_crc_ok,
    input  logic          rx_timeout,
    input  logic          rx_all_ones,
    input  logic [DW-1:0] rx_data,
    output logic          idle_tick,
    output logic          idle_level,
    output logic          done,
    output logic [2:0]    err,
    output logic [DW-1:0] rd_data,
    output logic          link_lost,
    output logic          addr_inval
);
    localparam int unsigned LMAX =
        umax(umax(umax(INIT_CLKS, PAD_CLKS), umax(PRIME_CLKS, BRK_LO_CLKS)),
             umax(umax(BRK_HI_CLKS, ECHO_CLKS), BRK_SET_CLKS));
    localparam int unsigned CW = $clog2(LMAX + 1);
    localparam int unsigned TRY_LIM = (CMD_TRIES > 0) ? CMD_TRIES - 1 : 0;

    typedef struct packed {
        st_e           st;
        st_e           after;
        logic [CW-1:0] plen;
        logic          plvl;
        txk_e          kind;
        logic          in_term;
        err_e          err;
        logic          lost;
        logic          inval;
        logic [1:0]    bph;
        logic [DW-1:0] data;
    } ctl_t;

    ctl_t q, n;

    function automatic ctl_t pad_to(input ctl_t c, input int unsigned len,
                                    input logic lvl, input st_e nx);
        ctl_t r = c;
        r.plen  = CW'(len);
        r.plvl  = lvl;
        r.after = nx;
        r.st    = S_PADL;
        return r;
    endfunction

    // strobes into the submodules
    logic pace_go, pace_fin;
    logic busy_clr, busy_inc, busy_lim;
    logic ecrc_clr, ecrc_inc, ecrc_lim;
    logic try_clr,  try_inc,  try_lim;
    vrd_e vrd;

    lnk_pacer #(.CW(CW)) u_pacer (
        .clk   (clk),
        .rst   (rst),
        .start (pace_go),
        .len   (q.plen),
        .lvl   (q.plvl),
        .tick  (idle_tick),
        .level (idle_level),
        .fin   (pace_fin)
    );

    lnk_bcnt #(.LIM(MAX_BUSY)) u_busy (
        .clk(clk), .rst(rst), .clr(busy_clr), .inc(busy_inc), .at_lim(busy_lim)
    );

    lnk_bcnt #(.LIM(EPOLL_MAX)) u_ecrc (
        .clk(clk), .rst(rst), .clr(ecrc_clr), .inc(ecrc_inc), .at_lim(ecrc_lim)
    );

    lnk_bcnt #(.LIM(TRY_LIM)) u_try (
        .clk(clk), .rst(rst), .clr(try_clr), .inc(try_inc), .at_lim(try_lim)
    );

    lnk_verdict u_vrd (
        .tag      (rx_tag),
        .crc_ok   (rx_crc_ok),
        .timeout  (rx_timeout),
        .all_ones (rx_all_ones),
        .verdict  (vrd)
    );

    always_comb begin
        n        = q;
        pace_go  = 1'b0;
        busy_clr = 1'b0;
        busy_inc = 1'b0;
        ecrc_clr = 1'b0;
        ecrc_inc = 1'b0;
        try_clr  = 1'b0;
        try_inc  = 1'b0;

        unique case (q.st)
            S_PADL: begin
                pace_go = 1'b1;
                n.st    = S_PADW;
            end

            S_PADW: begin
                if (pace_fin) n.st = q.after;
            end

            S_IDLE: begin
                if (req_valid) begin
                    busy_clr  = 1'b1;
                    ecrc_clr  = 1'b1;
                    try_clr   = 1'b1;
                    n.err     = ERR_OK;
                    n.lost    = 1'b0;
                    n.inval   = 1'b0;
                    n.in_term = 1'b0;
                    if (ext_mode) begin
                        n.err = ERR_BUSY;
                        n.st  = S_DONE;
                    end else if (req_break) begin
                        n     = pad_to(n, BRK_LO_CLKS, 1'b0, S_BRK);
                        n.bph = 2'd1;
                    end else begin
                        n.kind = TXK_FULL;
                        n.st   = S_TX;
                    end
                end
            end

            S_BRK: begin
                unique case (q.bph)
                    2'd1: begin
                        n     = pad_to(q, BRK_HI_CLKS, 1'b1, S_BRK);
                        n.bph = 2'd2;
                    end
                    2'd2: begin
                        n     = pad_to(q, ECHO_CLKS, 1'b0, S_BRK);
                        n.bph = 2'd3;
                    end
                    default: begin
                        n       = pad_to(q, BRK_SET_CLKS, 1'b0, S_DONE);
                        n.bph   = 2'd0;
                        n.inval = 1'b1;
                        n.err   = ERR_OK;
                    end
                endcase
            end

            S_TX: n.st = S_TXW;

            S_TXW: begin
                if (tx_done) n.st = S_RX;
            end

            S_RX: n.st = S_RXW;

            S_RXW: begin
                if (rx_done) begin
                    if (q.in_term) begin
                        n.lost = (vrd != V_ACK);
                        n.err  = ERR_IO;
                        n      = pad_to(n, PRIME_CLKS, 1'b0, S_DONE);
                    end else begin
                        unique case (vrd)
                            V_ACK: begin
                                n.data = rx_data;
                                n.err  = ERR_OK;
                                n      = pad_to(n, PRIME_CLKS, 1'b0, S_DONE);
                            end
                            V_BUSY: begin
                                if (!busy_lim) begin
                                    busy_inc = 1'b1;
                                    n.kind   = TXK_DPOLL;
                                end else begin
                                    n.kind    = TXK_TERM;
                                    n.in_term = 1'b1;
                                end
                                n = pad_to(n, PAD_CLKS, 1'b0, S_TX);
                            end
                            V_BADCRC: begin
                                if (!ecrc_lim) begin
                                    ecrc_inc = 1'b1;
                                    n.kind   = TXK_EPOLL;
                                    n        = pad_to(n, PAD_CLKS, 1'b0, S_TX);
                                end else begin
                                    n.err = ERR_IO;
                                    n     = pad_to(n, PRIME_CLKS, 1'b0, S_DONE);
                                end
                            end
                            V_CMDCRC: n = pad_to(n, PRIME_CLKS, 1'b0, S_RESEND);
                            V_NODEV: begin
                                n.err = ERR_NODEV;
                                n     = pad_to(n, PRIME_CLKS, 1'b0, S_DONE);
                            end
                            V_TMO: begin
                                n.err = ERR_TMO;
                                n     = pad_to(n, PRIME_CLKS, 1'b0, S_DONE);
                            end
                            default: begin
                                n.err = ERR_IO;
                                n     = pad_to(n, PRIME_CLKS, 1'b0, S_DONE);
                            end
                        endcase
                    end
                end
            end

            S_RESEND: begin
                if (try_lim) begin
                    n.err = ERR_IO;
                    n.st  = S_DONE;
                end else begin
                    try_inc  = 1'b1;
                    busy_clr = 1'b1;
                    ecrc_clr = 1'b1;
                    n.kind   = TXK_FULL;
                    n.st     = S_TX;
                end
            end

            S_DONE: n.st = S_IDLE;

            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= '0;
            q.st      <= S_PADL;
            q.after   <= S_IDLE;
            q.plen    <= CW'(INIT_CLKS);
            q.plvl    <= 1'b0;
            q.kind    <= TXK_FULL;
            q.err     <= ERR_OK;
        end else begin
            q <= n;
        end
    end

    assign req_ready  = (q.st == S_IDLE);
    assign tx_start   = (q.st == S_TX);
    assign tx_kind    = q.kind;
    assign rx_start   = (q.st == S_RX);
    assign done       = (q.st == S_DONE);
    assign err        = q.err;
    assign rd_data    = q.data;
    assign link_lost  = q.lost;
    assign addr_inval = (q.st == S_DONE) && q.inval;

endmodule

// File: rtl/lnk_poll_chk.sv
module lnk_poll_chk (
    input logic       clk,
    input logic       rst,
    input logic       ext_mode,
    input logic       req_valid,
    input logic       req_ready,
    input logic       tx_start,
    input logic       rx_start,
    input logic       idle_tick,
    input logic       done,
    input logic [2:0] err,
    input logic       link_lost,
    input logic       addr_inval
);
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_range_R13: assert property (@(posedge clk) disable iff (rst)
        done |-> (err <= 3'd4));

    assert_ext_reject_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ext_mode) |=> (done && err == 3'd4));

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !idle_tick);

    assert_frame_excl_R2: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> (!idle_tick && !rx_start));

    assert_inval_ok_R12: assert property (@(posedge clk) disable iff (rst)
        addr_inval |-> (done && err == 3'd0));

    assert_lost_io_R10: assert property (@(posedge clk) disable iff (rst)
        (done && link_lost) |-> (err == 3'd2));
endmodule

bind lnk_poll_seq lnk_poll_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ext_mode   (ext_mode),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .tx_start   (tx_start),
    .rx_start   (rx_start),
    .idle_tick  (idle_tick),
    .done       (done),
    .err        (err),
    .link_lost  (link_lost),
    .addr_inval (addr_inval)
);

// File: tb/sim_lnk_poll_seq.sv
`timescale 1ns/1ps
module sim_lnk_poll_seq;
    localparam int DW = 16;
    localparam int INIT_N = 7, PAD_N = 5, PRIME_N = 3;
    localparam int B0 = 4, B1 = 6, B2 = 2, B3 = 9;
    localparam int MAXB = 3, EMAX = 2, TRIES = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_mode = 1'b0, req_valid = 1'b0, req_break = 1'b0;
    logic req_ready, tx_start, rx_start, idle_tick, idle_level, done;
    logic link_lost, addr_inval;
    logic [1:0] tx_kind;
    logic tx_done = 1'b0, rx_done = 1'b0;
    logic [1:0] rx_tag = 2'd0;
    logic rx_crc_ok = 1'b1, rx_timeout = 1'b0, rx_all_ones = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic [2:0] err;
    logic [DW-1:0] rd_data;

    always #2.5 clk = ~clk;

    lnk_poll_seq #(
        .DW(DW), .INIT_CLKS(INIT_N), .PAD_CLKS(PAD_N), .PRIME_CLKS(PRIME_N),
        .BRK_LO_CLKS(B0), .BRK_HI_CLKS(B1), .ECHO_CLKS(B2), .BRK_SET_CLKS(B3),
        .MAX_BUSY(MAXB), .EPOLL_MAX(EMAX), .CMD_TRIES(TRIES)
    ) u0 (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .req_valid(req_valid),
        .req_break(req_break), .req_ready(req_ready), .tx_start(tx_start),
        .tx_kind(tx_kind), .tx_done(tx_done), .rx_start(rx_start),
        .rx_done(rx_done), .rx_tag(rx_tag), .rx_crc_ok(rx_crc_ok),
        .rx_timeout(rx_timeout), .rx_all_ones(rx_all_ones), .rx_data(rx_data),
        .idle_tick(idle_tick), .idle_level(idle_level), .done(done), .err(err),
        .rd_data(rd_data), .link_lost(link_lost), .addr_inval(addr_inval)
    );

    // response codes: 0 ack,1 busy,2 err,3 cmd-corrupt,4 bad check,5 all ones,6 timeout
    int script [0:63];
    int sn, sidx;
    logic [DW-1:0] dval;
    int n_chk = 0, n_bad = 0;
    int tick_n, lvl1_n, pre1_n, n_full, n_dp, n_ep, n_term, done_n = 0, dbl_n = 0;
    int tx_cd = 0, rx_cd = 0;
    logic prev_done = 1'b0;
    logic [2:0] l_err;
    logic [DW-1:0] l_data;
    logic l_lost, l_inval;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // slave model and monitor, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            tx_done = 1'b0;
            rx_done = 1'b0;
            if (tx_cd > 0) begin
                tx_cd--;
                if (tx_cd == 0) tx_done = 1'b1;
            end
            if (rx_cd > 0) begin
                rx_cd--;
                if (rx_cd == 0) begin
                    int code;
                    code = (sidx < sn) ? script[sidx] : 0;
                    sidx++;
                    rx_done     = 1'b1;
                    rx_timeout  = (code == 6);
                    rx_crc_ok   = !(code == 4 || code == 5);
                    rx_all_ones = (code == 5);
                    rx_tag      = (code <= 3) ? 2'(code) : 2'd0;
                    rx_data     = dval;
                end
            end
            if (tx_start) begin
                tx_cd = 2;
                case (tx_kind)
                    2'd0: n_full++;
                    2'd1: n_dp++;
                    2'd2: n_ep++;
                    default: n_term++;
                endcase
            end
            if (rx_start) rx_cd = 3;
            if (idle_tick) begin
                tick_n++;
                if (idle_level) lvl1_n++;
                else if (lvl1_n == 0) pre1_n++;
            end
            if (done) begin
                done_n++;
                l_err   = err;
                l_data  = rd_data;
                l_lost  = link_lost;
                l_inval = addr_inval;
                if (prev_done) dbl_n++;
            end
            prev_done = done;
        end
    end

    task automatic clr_stats();
        tick_n = 0; lvl1_n = 0; pre1_n = 0;
        n_full = 0; n_dp = 0; n_ep = 0; n_term = 0; sidx = 0;
    endtask

    task automatic run(input logic brk);
        int base;
        @(posedge clk); #1;
        clr_stats();
        base = done_n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_break = brk;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (done_n == base) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic push(input int code);
        script[sn] = code;
        sn++;
    endtask

    task automatic reset_script();
        sn = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R13 watchdog actual=expired expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        sn = 0; sidx = 0; dval = '0;
        clr_stats();
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", int'(req_ready), 0);
        chk("R13", "done in reset", int'(done), 0);
        @(posedge clk); #1;
        clr_stats();
        rst = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        chk("R1", "init ticks", tick_n, INIT_N);
        chk("R1", "init level1 ticks", lvl1_n, 0);

        // plain acknowledge
        reset_script(); push(0); dval = 16'hC3A5;
        run(1'b0);
        chk("R2", "ack err", int'(l_err), 0);
        chk("R2", "ack data", int'(l_data), 16'hC3A5);
        chk("R2", "ack full frames", n_full, 1);
        chk("R8", "ack prime ticks", tick_n, PRIME_N);
        chk("R8", "ack level1", lvl1_n, 0);
        chk("R12", "no inval on transfer", int'(l_inval), 0);

        // busy depths within budget
        for (int k = 1; k <= MAXB; k++) begin
            reset_script();
            for (int i = 0; i < k; i++) push(1);
            push(0); dval = 16'(16'h1100 + k);
            run(1'b0);
            chk("R3", "busy dpolls", n_dp, k);
            chk("R3", "busy ticks", tick_n, k * PAD_N + PRIME_N);
            chk("R3", "busy err", int'(l_err), 0);
            chk("R3", "busy data", int'(l_data), 16'h1100 + k);
            chk("R4", "no term", n_term, 0);
        end

        // busy exhausted, terminate acknowledged, then timed out / errored
        for (int t = 0; t < 3; t++) begin
            reset_script();
            for (int i = 0; i <= MAXB; i++) push(1);
            push(t == 0 ? 0 : (t == 1 ? 6 : 2));
            run(1'b0);
            chk("R4", "exhaust dpolls", n_dp, MAXB);
            chk("R4", "exhaust term", n_term, 1);
            chk("R4", "exhaust err", int'(l_err), 2);
            chk("R4", "exhaust ticks", tick_n, (MAXB + 1) * PAD_N + PRIME_N);
            chk("R10", "lost flag", int'(l_lost), (t == 0) ? 0 : 1);
        end

        // bad check codes
        for (int j = 1; j <= EMAX + 1; j++) begin
            reset_script();
            for (int i = 0; i < j; i++) push(4);
            push(0); dval = 16'h7E00;
            run(1'b0);
            chk("R5", "epolls", n_ep, (j <= EMAX) ? j : EMAX);
            chk("R5", "epoll err", int'(l_err), (j <= EMAX) ? 0 : 2);
            chk("R5", "epoll ticks", tick_n,
                ((j <= EMAX) ? j : EMAX) * PAD_N + PRIME_N);
        end

        // command-corrupt resends
        for (int m = 1; m <= TRIES; m++) begin
            reset_script();
            for (int i = 0; i < m; i++) push(3);
            push(0);
            run(1'b0);
            chk("R6", "resend frames", n_full, (m < TRIES) ? m + 1 : TRIES);
            chk("R6", "resend err", int'(l_err), (m < TRIES) ? 0 : 2);
            chk("R6", "resend ticks", tick_n, ((m < TRIES) ? m + 1 : TRIES) * PRIME_N);
        end

        // budgets refreshed by a resend
        reset_script();
        for (int i = 0; i < MAXB; i++) push(1);
        push(3);
        for (int i = 0; i < MAXB; i++) push(1);
        push(0);
        run(1'b0);
        chk("R6", "refresh dpolls", n_dp, 2 * MAXB);
        chk("R6", "refresh term", n_term, 0);
        chk("R6", "refresh err", int'(l_err), 0);
        chk("R6", "refresh frames", n_full, 2);

        // mixed busy then bad check then ack
        reset_script(); push(1); push(4); push(0);
        run(1'b0);
        chk("R5", "mix dpoll", n_dp, 1);
        chk("R5", "mix epoll", n_ep, 1);
        chk("R8", "mix ticks", tick_n, 2 * PAD_N + PRIME_N);

        // immediate failures
        reset_script(); push(2);
        run(1'b0);
        chk("R7", "generic err", int'(l_err), 2);
        chk("R8", "generic ticks", tick_n, PRIME_N);
        chk("R7", "generic frames", n_full, 1);
        reset_script(); push(6);
        run(1'b0);
        chk("R7", "timeout err", int'(l_err), 1);
        chk("R8", "timeout ticks", tick_n, PRIME_N);
        reset_script(); push(5);
        run(1'b0);
        chk("R9", "nodev err", int'(l_err), 3);
        chk("R9", "nodev epolls", n_ep, 0);

        // link reset
        reset_script();
        run(1'b1);
        chk("R12", "break ticks", tick_n, B0 + B1 + B2 + B3);
        chk("R12", "break high ticks", lvl1_n, B1);
        chk("R12", "break low lead", pre1_n, B0);
        chk("R12", "break inval", int'(l_inval), 1);
        chk("R12", "break err", int'(l_err), 0);
        chk("R12", "break frames", n_full + n_dp + n_ep + n_term, 0);

        // external mode refusal
        ext_mode = 1'b1;
        reset_script(); push(0);
        run(1'b0);
        chk("R11", "ext xfer err", int'(l_err), 4);
        chk("R11", "ext xfer frames", n_full, 0);
        chk("R11", "ext xfer ticks", tick_n, 0);
        run(1'b1);
        chk("R11", "ext break err", int'(l_err), 4);
        chk("R11", "ext break ticks", tick_n, 0);
        chk("R11", "ext break inval", int'(l_inval), 0);
        ext_mode = 1'b0;

        reset_script(); push(0); dval = 16'h0F0F;
        run(1'b0);
        chk("R2", "after ext data", int'(l_data), 16'h0F0F);
        chk("R13", "done double cycles", dbl_n, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule